// File: doc/BRIEF.md
# Sample-Phase Tuning Sweep with Circular Window Selection

This block drives a receive sample-phase calibration. After a start pulse it steps through the sample phases of one card-clock period. At each step it asks an external phase unit to apply the phase and waits for that unit to acknowledge. It then asks an external command unit to send a tuning pattern, and it stores the pass or fail result that comes back. Results are kept in a pass mask with one bit per phase.

There are 32 phases. The sweep makes 40 attempts, so the first eight phases are tested a second time after the counter wraps. Once the last attempt is recorded, a serial scanner walks the mask. It finds the longest group of consecutive passing phases, and the group may cross from phase 31 back to phase 0. The block reports the centre of that group as the chosen phase, or it raises an error flag when nothing passed.

The result is held until the next start pulse.

Top module: `tune_phase_sel`

## Requirements
- R1: After reset, `phase_req_o`, `tune_req_o`, `done_o`, `err_o` and `best_o` are all zero.
- R2: `phase_req_o` and `tune_req_o` are never high together. Once `phase_req_o` is raised, it stays high until the cycle in which `phase_ack_i` is seen.
- R3: `tune_req_o` rises only in the cycle after `phase_req_o` and `phase_ack_i` were both high. `tune_pass_i` is sampled in the cycle where `tune_ack_i` is high.
- R4: One sweep issues exactly 40 phase requests. Attempt k (counting from 0) presents `phase_o` = k mod 32.
- R5: Attempt k writes bit (k mod 32) of the pass mask: 1 on pass, 0 on fail. A later attempt on the same phase replaces the earlier result.
- R6: If no mask bit is set, the sweep ends with `done_o`=1, `err_o`=1 and `best_o`=0.
- R7: If every mask bit is set, the sweep ends with `err_o`=0 and `best_o`=0.
- R8: Otherwise `best_o` = (S + L/2) mod 32, using integer division. L is the length of the longest run of set bits, where runs may wrap from bit 31 to bit 0, and S is the start of that run.
- R9: Run starts are considered in order: first the lowest set bit, then each later run start in increasing bit position. A run only replaces the current best if it is strictly longer.
- R10: `done_o`, `err_o` and `best_o` stay unchanged until the next `start_i`. A `start_i` pulse that arrives while a sweep is running is ignored.
- R11: `done_o` rises no more than 70 cycles after the cycle that carries the last `tune_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a sweep; ignored while a sweep is running |
| phase_req_o | output | 1 | Request to apply `phase_o` |
| phase_o | output | 5 | Sample phase for the current attempt |
| phase_ack_i | input | 1 | External unit reports the phase is applied |
| tune_req_o | output | 1 | Request to send a tuning pattern |
| tune_ack_i | input | 1 | Tuning transfer has finished |
| tune_pass_i | input | 1 | Result of the transfer, valid with `tune_ack_i` |
| done_o | output | 1 | Sweep and search are complete |
| err_o | output | 1 | No phase passed |
| best_o | output | 5 | Chosen sample phase |

## Verification
The assertions assume the following about the external units:
- each acknowledge arrives only while the matching request is high, and lasts one cycle;
- `tune_pass_i` is valid in the same cycle as `tune_ack_i`.

The stimulus meets these assumptions by design. It waits to see a request at a falling edge, then waits a random 0 to 3 cycles, then drives the acknowledge for exactly one cycle.

The pass and fail patterns include:
- directed cases: all fail, all pass, a window that wraps, equal-length runs, and second-pass overwrites;
- seeded random masks.

A start pulse is also injected in the middle of one sweep, to check that it is ignored.

// File: rtl/tune_pkg.sv
package tune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREQ,
    ST_TREQ,
    ST_KICK,
    ST_WAIT,
    ST_DONE
  } sweep_st_e;
endpackage

// File: rtl/tune_sweep_ctrl.sv
module tune_sweep_ctrl
  import tune_pkg::*;
#(
  parameter int NPH    = 32,
  parameter int NSTEPS = 40
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   phase_ack_i,
  input  logic                   tune_ack_i,
  input  logic                   tune_pass_i,
  input  logic                   fin_i,
  output logic                   phase_req_o,
  output logic [$clog2(NPH)-1:0] phase_o,
  output logic                   tune_req_o,
  output logic                   go_o,
  output logic                   done_o,
  output logic [NPH-1:0]         mask_o
);
  localparam int PW = $clog2(NPH);
  localparam int SW = $clog2(NSTEPS + 1);

  sweep_st_e       st_q;
  logic [SW-1:0]   step_q;
  logic [PW-1:0]   ph_q;
  logic [NPH-1:0]  mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      ph_q   <= '0;
      mask_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          st_q   <= ST_PREQ;
          step_q <= '0;
          ph_q   <= '0;
          mask_q <= '0;
        end
        ST_PREQ: if (phase_ack_i) st_q <= ST_TREQ;
        ST_TREQ: if (tune_ack_i) begin
          mask_q[ph_q] <= tune_pass_i;
          if (step_q == SW'(NSTEPS - 1)) begin
            st_q <= ST_KICK;
          end else begin
            step_q <= step_q + 1'b1;
            ph_q   <= (ph_q == PW'(NPH - 1)) ? '0 : ph_q + 1'b1;
            st_q   <= ST_PREQ;
          end
        end
        ST_KICK: st_q <= ST_WAIT;
        ST_WAIT: if (fin_i) st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign phase_req_o = (st_q == ST_PREQ);
  assign tune_req_o  = (st_q == ST_TREQ);
  assign go_o        = (st_q == ST_KICK);
  assign done_o      = (st_q == ST_DONE);
  assign phase_o     = ph_q;
  assign mask_o      = mask_q;

  a_r2_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phase_req_o && tune_req_o));

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_req_o && !phase_ack_i |=> phase_req_o);

  a_r3_tune_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tune_req_o) |-> $past(phase_req_o && phase_ack_i));

  a_r4_phase_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_req_o) && $past(tune_req_o) |-> phase_o == PW'($past(phase_o) + 1'b1));

  a_r10_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tune_req_o && !tune_ack_i |=> tune_req_o);
endmodule

// File: rtl/tune_win_search.sv
module tune_win_search #(
  parameter int NPH = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   go_i,
  input  logic [NPH-1:0]         mask_i,
  output logic                   fin_o,
  output logic                   err_o,
  output logic [$clog2(NPH)-1:0] best_o
);
  localparam int PW = $clog2(NPH);
  localparam int IW = PW + 1;
  localparam int LW = PW + 1;

  function automatic logic [PW-1:0] low_set(input logic [NPH-1:0] m);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NPH - 1; i >= 0; i--) if (m[i]) r = PW'(i);
    return r;
  endfunction

  logic          act_q, in_run_q;
  logic [IW-1:0] idx_q;
  logic [PW-1:0] cur_start_q, bst_start_q;
  logic [LW-1:0] cur_len_q, bst_len_q;

  logic          bit_c, n_in_run, last_c;
  logic [PW-1:0] n_cur_start, n_bst_start;
  logic [LW-1:0] n_cur_len, n_bst_len, mid_c;

  always_comb begin
    bit_c       = mask_i[idx_q[PW-1:0]];
    n_in_run    = in_run_q;
    n_cur_start = cur_start_q;
    n_cur_len   = cur_len_q;
    n_bst_start = bst_start_q;
    n_bst_len   = bst_len_q;
    if (bit_c) begin
      if (in_run_q) begin
        n_cur_len = cur_len_q + 1'b1;
      end else begin
        n_in_run    = 1'b1;
        n_cur_start = idx_q[PW-1:0];
        n_cur_len   = LW'(1);
      end
    end else if (in_run_q) begin
      n_in_run = 1'b0;
      // strict compare keeps the earlier run on a tie
      if (cur_len_q > bst_len_q) begin
        n_bst_start = cur_start_q;
        n_bst_len   = cur_len_q;
      end
    end
    last_c = (idx_q >= IW'(NPH - 1)) && !n_in_run;
    mid_c  = LW'(n_bst_start) + (n_bst_len >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      in_run_q    <= 1'b0;
      idx_q       <= '0;
      cur_start_q <= '0;
      cur_len_q   <= '0;
      bst_start_q <= '0;
      bst_len_q   <= '0;
      fin_o       <= 1'b0;
      err_o       <= 1'b0;
      best_o      <= '0;
    end else begin
      fin_o <= 1'b0;
      if (go_i) begin
        in_run_q    <= 1'b0;
        cur_start_q <= '0;
        cur_len_q   <= '0;
        bst_start_q <= '0;
        bst_len_q   <= '0;
        best_o      <= '0;
        err_o       <= 1'b0;
        if (mask_i == '0) begin
          act_q <= 1'b0;
          err_o <= 1'b1;
          fin_o <= 1'b1;
        end else if (&mask_i) begin
          act_q <= 1'b0;
          fin_o <= 1'b1;
        end else begin
          act_q <= 1'b1;
          idx_q <= IW'(low_set(mask_i));
        end
      end else if (act_q) begin
        in_run_q    <= n_in_run;
        cur_start_q <= n_cur_start;
        cur_len_q   <= n_cur_len;
        bst_start_q <= n_bst_start;
        bst_len_q   <= n_bst_len;
        idx_q       <= idx_q + 1'b1;
        if (last_c) begin
          act_q  <= 1'b0;
          fin_o  <= 1'b1;
          best_o <= mid_c[PW-1:0];
        end
      end
    end
  end

  a_r11_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> idx_q <= IW'(2 * NPH - 2));

  a_r8_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> cur_len_q < LW'(NPH) && bst_len_q < LW'(NPH));

  a_r6_err_no_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o && err_o |-> best_o == '0);

  a_r8_mask_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && $past(act_q) |-> $stable(mask_i));
endmodule

// File: rtl/tune_phase_sel.sv
module tune_phase_sel #(
  parameter int NPH    = 32,
  parameter int NSTEPS = 40
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  output logic                   phase_req_o,
  output logic [$clog2(NPH)-1:0] phase_o,
  input  logic                   phase_ack_i,
  output logic                   tune_req_o,
  input  logic                   tune_ack_i,
  input  logic                   tune_pass_i,
  output logic                   done_o,
  output logic                   err_o,
  output logic [$clog2(NPH)-1:0] best_o
);
  logic           go, fin;
  logic [NPH-1:0] mask;

  tune_sweep_ctrl #(.NPH(NPH), .NSTEPS(NSTEPS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .phase_ack_i (phase_ack_i),
    .tune_ack_i  (tune_ack_i),
    .tune_pass_i (tune_pass_i),
    .fin_i       (fin),
    .phase_req_o (phase_req_o),
    .phase_o     (phase_o),
    .tune_req_o  (tune_req_o),
    .go_o        (go),
    .done_o      (done_o),
    .mask_o      (mask)
  );

  tune_win_search #(.NPH(NPH)) u_search (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .mask_i (mask),
    .fin_o  (fin),
    .err_o  (err_o),
    .best_o (best_o)
  );

  a_r10_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(best_o) && $stable(err_o));

  a_r10_idle_while_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !phase_req_o && !tune_req_o);
endmodule

// File: tb/tune_phase_sel_tb.sv
module tune_phase_sel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, phase_ack_i = 1'b0, tune_ack_i = 1'b0, tune_pass_i = 1'b0;
  logic phase_req_o, tune_req_o, done_o, err_o;
  logic [4:0] phase_o, best_o;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tune_phase_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
    .phase_req_o(phase_req_o), .phase_o(phase_o), .phase_ack_i(phase_ack_i),
    .tune_req_o(tune_req_o), .tune_ack_i(tune_ack_i), .tune_pass_i(tune_pass_i),
    .done_o(done_o), .err_o(err_o), .best_o(best_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns -1 when nothing passed
  function automatic int ref_best(input logic [31:0] m);
    int lo, bl, bs, len;
    if (m == 32'h0) return -1;
    if (m == 32'hffff_ffff) return 0;
    lo = 0;
    for (int i = 31; i >= 0; i--) if (m[i]) lo = i;
    bl = 0; bs = 0;
    for (int s = lo; s < 32; s++) begin
      if (m[s] && (s == lo || !m[s-1])) begin
        len = 0;
        while (len < 32 && m[(s + len) % 32]) len++;
        if (len > bl) begin bl = len; bs = s; end
      end
    end
    return (bs + bl / 2) % 32;
  endfunction

  task automatic wait_for(ref logic sig);
    while (!sig) @(negedge clk);
  endtask

  task automatic run_sweep(input logic [39:0] att, input string tag, input bit poke);
    logic [31:0] m;
    int exp, lat, ph_bad, nreq;
    logic [4:0] hb;
    logic he;
    m = '0;
    for (int k = 0; k < 40; k++) m[k % 32] = att[k];
    exp = ref_best(m);
    ph_bad = 0; nreq = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int k = 0; k < 40; k++) begin
      wait_for(phase_req_o);
      nreq++;
      if (phase_o != 5'(k % 32)) ph_bad++;
      if (poke && k == 10) start_i = 1'b1;
      repeat ($urandom_range(0, 3)) @(negedge clk);
      start_i = 1'b0;
      if (!phase_req_o || tune_req_o) ph_bad++;
      phase_ack_i = 1'b1;
      @(negedge clk); phase_ack_i = 1'b0;
      wait_for(tune_req_o);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      tune_pass_i = att[k]; tune_ack_i = 1'b1;
      @(negedge clk); tune_ack_i = 1'b0; tune_pass_i = 1'b0;
    end
    lat = 1;
    while (!done_o && lat < 200) begin
      if (phase_req_o) nreq++;
      @(negedge clk); lat++;
    end
    chk(ph_bad == 0, {"R4 phase order ", tag}, ph_bad, 0);
    chk(nreq == 40, {"R4 request count ", tag}, nreq, 40);
    chk(lat <= 70, {"R11 latency ", tag}, lat, 70);
    chk(done_o == 1'b1, {"R10 done ", tag}, int'(done_o), 1);
    chk(err_o == (exp < 0), {"R6 err flag ", tag}, int'(err_o), int'(exp < 0));
    chk(int'(best_o) == ((exp < 0) ? 0 : exp), {"R8 best ", tag}, int'(best_o), (exp < 0) ? 0 : exp);
    hb = best_o; he = err_o;
    repeat (5) @(negedge clk);
    chk(done_o && best_o == hb && err_o == he && !phase_req_o, {"R10 hold ", tag},
        int'(best_o), int'(hb));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [39:0] a;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!phase_req_o && !tune_req_o && !done_o && !err_o && best_o == 0, "R1 reset outputs",
        int'({phase_req_o, tune_req_o, done_o, err_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!phase_req_o && !done_o, "R1 idle after reset", int'(phase_req_o), 0);

    run_sweep(40'h0, "R6 all fail", 1'b0);
    run_sweep({40{1'b1}}, "R7 all pass", 1'b0);
    a = '0; for (int k = 5; k <= 9; k++) begin a[k] = 1'b1; end
    run_sweep(a, "R8 window 5..9", 1'b0);
    // first pass on phases 0..7 succeeds, retest fails: mask ends with them clear
    a = '0; for (int k = 0; k < 8; k++) begin a[k] = 1'b1; end
    a[20] = 1'b1; a[21] = 1'b1;
    run_sweep(a, "R5 overwrite", 1'b0);
    a = '0; for (int k = 0; k < 3; k++) begin a[k] = 1'b1; a[k+32] = 1'b1; end
    for (int k = 28; k < 32; k++) begin a[k] = 1'b1; end
    run_sweep(a, "R8 wrap window", 1'b0);
    a = '0; for (int k = 3; k <= 6; k++) begin a[k] = 1'b1; a[k+17] = 1'b1; end
    run_sweep(a, "R9 tie earlier", 1'b0);
    // tie with bit 0 set and bit 31 set: run from 0 counted first
    a = '0; a[0] = 1'b1; a[1] = 1'b1; a[32] = 1'b1; a[33] = 1'b1; a[31] = 1'b1; a[10] = 1'b1;
    a[11] = 1'b1; a[12] = 1'b1;
    run_sweep(a, "R9 tie wrap", 1'b0);
    a = '0; a[31] = 1'b1;
    run_sweep(a, "R8 single bit 31", 1'b0);
    a = '0; for (int k = 10; k < 20; k++) begin a[k] = 1'b1; end
    run_sweep(a, "R10 start ignored busy", 1'b1);
    a = {40{1'b1}}; a[33] = 1'b0;
    run_sweep(a, "R5 R8 retest fail", 1'b0);
    for (int r = 0; r < 8; r++) begin
      a = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      if (r % 2 == 1) a = a | {$urandom(), $urandom()};
      run_sweep(a, "R3 R8 random", 1'b0);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule